// File: doc/BRIEF.md
# Intra 16x16 Mode SAD Selector

This block scores three whole-block intra predictions for one 16x16 luma block. A block begins with a `start` pulse. With that pulse the block captures the 33-byte neighbour array, an externally computed DC value and a 3-bit mode-enable mask. Sixteen source rows of 16 pixels then arrive over a valid/ready stream. For each accepted row, the block adds that row's sum of absolute differences to three accumulators at once: one against the vertical prediction (top pixels), one against the horizontal prediction (left pixel of that row, copied across the row) and one against a flat DC prediction.

In the cycle after the last source row, the block selects a mode. Each disabled mode's cost is replaced by 2^30, and a fixed tie-break then picks the winner. The winning mode code and its cost stay on `best_mode`/`best_cost`. The 16 rows of the winning prediction then leave on a second valid/ready stream, and `done` pulses once after the final row is taken.

Back-pressure rules: the block accepts a source row only when `src_valid` and `src_ready` are both high. `src_ready` is high only while a block is loading. An output row is presented with `pred_valid`, and it is held with unchanged data until `pred_ready` is seen. Gaps in `src_valid` and stalls on `pred_ready` delay the block but do not change any result.

Top module: `intra16_mode_picker`

## Requirements
- R1: A `start` pulse seen while the block is idle begins a block. `src_ready` is then high until exactly 16 rows have been accepted, and it is low in every other state. After reset, `src_ready`, `pred_valid` and `done` are 0, `best_mode` is 0 and `best_cost` is 0.
- R2: The vertical cost is the sum of |src[r][c] - nbr[17+c]| over all 256 pixels. Neighbour byte i is `nbr_in[8*i+7:8*i]`, and column c of a row is bits `8*c+7:8*c`.
- R3: The horizontal cost is the sum of |src[r][c] - nbr[15-r]| over all pixels. Row 0 is the first row accepted.
- R4: The DC cost is the sum of |src[r][c] - dc_in|.
- R5: Mask bit 0 enables vertical, bit 1 enables horizontal and bit 2 enables DC. A disabled mode's cost is 2^30 for both comparison and reporting.
- R6: Mode codes are 0 for vertical, 1 for horizontal and 2 for DC. Vertical wins when its cost is not above either other cost. Otherwise horizontal wins when its cost is not above the DC cost. Otherwise DC wins. `best_cost` is the winner's cost.
- R7: The output stream carries 16 rows, row 0 first. Vertical rows are nbr[17..32], horizontal row r is nbr[15-r] in every column, and DC rows are `dc_in` in every column.
- R8: While `pred_valid` is high and `pred_ready` is low, `pred_valid` and `pred_data` stay unchanged on the next cycle.
- R9: `done` is high for exactly one cycle, the cycle after the last output row is accepted.
- R10: A `start` pulse while rows are being loaded or emitted is ignored. No new block begins, so `src_ready` stays low after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a block when idle |
| mode_mask | input | 3 | Mode enables, captured at start |
| nbr_in | input | 264 | 33 neighbour bytes, captured at start |
| dc_in | input | 8 | DC prediction value, captured at start |
| src_valid | input | 1 | Source row valid |
| src_ready | output | 1 | Source row accepted when high with valid |
| src_row | input | 128 | Source row, 16 pixels |
| pred_valid | output | 1 | Prediction row valid |
| pred_ready | input | 1 | Downstream takes the prediction row |
| pred_row | output | 128 | Prediction row of the winning mode |
| best_mode | output | 2 | Winning mode code |
| best_cost | output | 32 | Winning cost |
| done | output | 1 | One-cycle pulse after the last output row |

## Verification
The bench sweeps every one of the eight mask values across source patterns that force ties. These include perfect matches for each mode, all-equal pixels that make all three costs zero, and maximum-contrast blocks at the 65280 ceiling. A wrong priority order would report mode 1 or 2 on an exact tie. A missing sentinel would let a disabled mode with zero cost win, and a narrow accumulator would wrap at the ceiling. The all-disabled masks must report mode 0 at 2^30. Stalled `pred_ready` and gaps in `src_valid` expose designs that drop a row or advance under back-pressure. A `start` pulse during output exposes a design that re-arms itself.

// File: rtl/intra16_pkg.sv
package intra16_pkg;
  localparam int COST_W = 32;
  localparam logic [COST_W-1:0] BLOCKED_COST = 32'h4000_0000;
  localparam int NUM_MODES = 3;

  typedef enum logic [1:0] {
    MODE_VERT = 2'd0,
    MODE_HORZ = 2'd1,
    MODE_DC   = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PICK = 2'd2,
    ST_EMIT = 2'd3
  } phase_e;
endpackage

// File: rtl/intra16_pred_row.sv
module intra16_pred_row
  import intra16_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int BLK   = 16,
  localparam int RIDX_W = $clog2(BLK),
  localparam int NBR_W  = (2*BLK+1)*PIX_W,
  localparam int ROW_W  = BLK*PIX_W
) (
  input  mode_e             mode,
  input  logic [RIDX_W-1:0] ridx,
  input  logic [NBR_W-1:0]  nbr,
  input  logic [PIX_W-1:0]  dc,
  output logic [ROW_W-1:0]  row
);
  logic [PIX_W-1:0] left_pix;

  always_comb begin
    int li;
    li = BLK - 1 - int'(ridx);
    left_pix = nbr[li*PIX_W +: PIX_W];
  end

  for (genvar c = 0; c < BLK; c++) begin : g_col
    always_comb begin
      case (mode)
        MODE_VERT: row[c*PIX_W +: PIX_W] = nbr[(BLK+1+c)*PIX_W +: PIX_W];
        MODE_HORZ: row[c*PIX_W +: PIX_W] = left_pix;
        default:   row[c*PIX_W +: PIX_W] = dc;
      endcase
    end
  end
endmodule

// File: rtl/intra16_row_sad.sv
module intra16_row_sad #(
  parameter int PIX_W = 8,
  parameter int BLK   = 16,
  localparam int ROW_W = BLK*PIX_W,
  localparam int SUM_W = PIX_W + $clog2(BLK)
) (
  input  logic [ROW_W-1:0] src,
  input  logic [ROW_W-1:0] pred,
  output logic [SUM_W-1:0] sum
);
  always_comb begin
    logic [PIX_W-1:0] a, b, d;
    sum = '0;
    for (int c = 0; c < BLK; c++) begin
      a = src[c*PIX_W +: PIX_W];
      b = pred[c*PIX_W +: PIX_W];
      d = (a > b) ? a - b : b - a;
      sum = sum + SUM_W'(d);
    end
  end
endmodule

// File: rtl/intra16_mode_pick.sv
module intra16_mode_pick
  import intra16_pkg::*;
#(
  parameter int SAD_W = 16
) (
  input  logic [NUM_MODES-1:0][SAD_W-1:0] sads,
  input  logic [NUM_MODES-1:0]            enable,
  output mode_e                           mode,
  output logic [COST_W-1:0]               cost
);
  logic [NUM_MODES-1:0][COST_W-1:0] eff;

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_mask
    assign eff[g] = enable[g] ? {{(COST_W-SAD_W){1'b0}}, sads[g]} : BLOCKED_COST;
  end

  always_comb begin
    if (eff[0] <= eff[1] && eff[0] <= eff[2]) begin
      mode = MODE_VERT;
      cost = eff[0];
    end else if (eff[1] <= eff[2]) begin
      mode = MODE_HORZ;
      cost = eff[1];
    end else begin
      mode = MODE_DC;
      cost = eff[2];
    end
  end
endmodule

// File: rtl/intra16_mode_picker.sv
module intra16_mode_picker
  import intra16_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int BLK   = 16,
  localparam int RIDX_W = $clog2(BLK),
  localparam int NBR_W  = (2*BLK+1)*PIX_W,
  localparam int ROW_W  = BLK*PIX_W,
  localparam int SUM_W  = PIX_W + $clog2(BLK),
  localparam int SAD_W  = $clog2(BLK*BLK*((1<<PIX_W)-1)+1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [2:0]           mode_mask,
  input  logic [NBR_W-1:0]     nbr_in,
  input  logic [PIX_W-1:0]     dc_in,
  input  logic                 src_valid,
  output logic                 src_ready,
  input  logic [ROW_W-1:0]     src_row,
  output logic                 pred_valid,
  input  logic                 pred_ready,
  output logic [ROW_W-1:0]     pred_row,
  output logic [1:0]           best_mode,
  output logic [COST_W-1:0]    best_cost,
  output logic                 done
);
  phase_e                          phase;
  logic [RIDX_W-1:0]               rcnt;
  logic [NBR_W-1:0]                nbr_q;
  logic [PIX_W-1:0]                dc_q;
  logic [NUM_MODES-1:0]            mask_q;
  logic [NUM_MODES-1:0][SAD_W-1:0] acc;
  mode_e                           mode_q;
  logic [COST_W-1:0]               cost_q;
  logic                            done_q;

  mode_e                           pick_mode;
  logic [COST_W-1:0]               pick_cost;
  logic [NUM_MODES-1:0][ROW_W-1:0] cand_row;
  logic [NUM_MODES-1:0][SUM_W-1:0] row_sum;

  wire src_fire  = src_valid && src_ready;
  wire pred_fire = pred_valid && pred_ready;
  wire last_row  = (rcnt == RIDX_W'(BLK-1));

  assign src_ready  = (phase == ST_LOAD);
  assign pred_valid = (phase == ST_EMIT);
  assign best_mode  = mode_q;
  assign best_cost  = cost_q;
  assign done       = done_q;

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_lane
    intra16_pred_row #(.PIX_W(PIX_W), .BLK(BLK)) u_pred (
      .mode (mode_e'(m)),
      .ridx (rcnt),
      .nbr  (nbr_q),
      .dc   (dc_q),
      .row  (cand_row[m])
    );
    intra16_row_sad #(.PIX_W(PIX_W), .BLK(BLK)) u_sad (
      .src  (src_row),
      .pred (cand_row[m]),
      .sum  (row_sum[m])
    );
  end

  intra16_pred_row #(.PIX_W(PIX_W), .BLK(BLK)) u_out (
    .mode (mode_q),
    .ridx (rcnt),
    .nbr  (nbr_q),
    .dc   (dc_q),
    .row  (pred_row)
  );

  intra16_mode_pick #(.SAD_W(SAD_W)) u_pick (
    .sads   (acc),
    .enable (mask_q),
    .mode   (pick_mode),
    .cost   (pick_cost)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= ST_IDLE;
      rcnt   <= '0;
      nbr_q  <= '0;
      dc_q   <= '0;
      mask_q <= '0;
      acc    <= '0;
      mode_q <= MODE_VERT;
      cost_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase)
        ST_IDLE: begin
          if (start) begin
            nbr_q  <= nbr_in;
            dc_q   <= dc_in;
            mask_q <= mode_mask;
            acc    <= '0;
            rcnt   <= '0;
            phase  <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (src_fire) begin
            for (int m = 0; m < NUM_MODES; m++)
              acc[m] <= acc[m] + SAD_W'(row_sum[m]);
            rcnt <= rcnt + 1'b1;
            if (last_row) phase <= ST_PICK;
          end
        end
        ST_PICK: begin
          mode_q <= pick_mode;
          cost_q <= pick_cost;
          rcnt   <= '0;
          phase  <= ST_EMIT;
        end
        default: begin
          if (pred_fire) begin
            rcnt <= rcnt + 1'b1;
            if (last_row) begin
              phase  <= ST_IDLE;
              done_q <= 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/intra16_mode_picker_chk.sv
module intra16_mode_picker_chk #(
  parameter int ROW_W  = 128,
  parameter int COST_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              src_ready,
  input logic              pred_valid,
  input logic              pred_ready,
  input logic [ROW_W-1:0]  pred_row,
  input logic [1:0]        best_mode,
  input logic [COST_W-1:0] best_cost,
  input logic              done
);
  p_streams_apart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_ready && pred_valid));

  p_cost_ceiling_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |-> best_cost <= 32'h4000_0000);

  p_mode_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |-> best_mode != 2'd3);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid && !pred_ready |=> pred_valid && $stable(pred_row));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(pred_valid && pred_ready));

  p_no_rearm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid && start |=> !src_ready);
endmodule

bind intra16_mode_picker intra16_mode_picker_chk #(.ROW_W(ROW_W), .COST_W(intra16_pkg::COST_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .src_ready  (src_ready),
  .pred_valid (pred_valid),
  .pred_ready (pred_ready),
  .pred_row   (pred_row),
  .best_mode  (best_mode),
  .best_cost  (best_cost),
  .done       (done)
);

// File: tb/intra16_mode_picker_bench.sv
module intra16_mode_picker_bench;
  localparam int BLK = 16;
  localparam int BLOCKED = 1 << 30;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [2:0]   mode_mask = '0;
  logic [263:0] nbr_in = '0;
  logic [7:0]   dc_in = '0;
  logic         src_valid = 1'b0;
  logic         src_ready;
  logic [127:0] src_row = '0;
  logic         pred_valid;
  logic         pred_ready = 1'b0;
  logic [127:0] pred_row;
  logic [1:0]   best_mode;
  logic [31:0]  best_cost;
  logic         done;

  intra16_mode_picker u_intra16_mode_picker (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_mask(mode_mask),
    .nbr_in(nbr_in), .dc_in(dc_in), .src_valid(src_valid), .src_ready(src_ready),
    .src_row(src_row), .pred_valid(pred_valid), .pred_ready(pred_ready),
    .pred_row(pred_row), .best_mode(best_mode), .best_cost(best_cost), .done(done)
  );

  always #2 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  int unsigned seed = 32'h1234_5678;

  logic [7:0] src [BLK][BLK];
  logic [7:0] nbr [33];
  logic [7:0] dc;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rnd8();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed[23:16];
  endfunction

  function automatic logic [7:0] pred_pix(int m, int r, int c);
    if (m == 0) return nbr[17+c];
    if (m == 1) return nbr[15-r];
    return dc;
  endfunction

  function automatic int mode_cost(int m, logic [2:0] mask);
    int s = 0;
    if (!mask[m]) return BLOCKED;
    for (int r = 0; r < BLK; r++)
      for (int c = 0; c < BLK; c++) begin
        int d = int'(src[r][c]) - int'(pred_pix(m, r, c));
        s += (d < 0) ? -d : d;
      end
    return s;
  endfunction

  function automatic logic [127:0] pack_row(int m, int r);
    logic [127:0] v;
    for (int c = 0; c < BLK; c++) v[c*8 +: 8] = pred_pix(m, r, c);
    return v;
  endfunction

  task automatic fill(input int p);
    dc = rnd8();
    for (int i = 0; i < 33; i++) nbr[i] = rnd8();
    for (int r = 0; r < BLK; r++)
      for (int c = 0; c < BLK; c++)
        case (p)
          0: src[r][c] = rnd8();
          1: src[r][c] = nbr[17+c];
          2: src[r][c] = nbr[15-r];
          3: src[r][c] = dc;
          4: src[r][c] = 8'd100;
          default: src[r][c] = 8'd255;
        endcase
    if (p == 4) begin
      dc = 8'd100;
      for (int i = 0; i < 33; i++) nbr[i] = 8'd100;
    end
    if (p == 5) begin
      dc = 8'd0;
      for (int i = 0; i < 33; i++) nbr[i] = 8'd0;
    end
  endtask

  task automatic run_block(input int p, input logic [2:0] mask);
    int cv, ch, cd, em, ec, r, k;
    bit stall, gapped, first, acc_row, take, poke;
    fill(p);
    stall = p[0];
    poke = (p == 2);
    cv = mode_cost(0, mask); ch = mode_cost(1, mask); cd = mode_cost(2, mask);
    if (cv <= ch && cv <= cd) begin em = 0; ec = cv; end
    else if (ch <= cd) begin em = 1; ec = ch; end
    else begin em = 2; ec = cd; end

    @(negedge clk);
    start = 1'b1; mode_mask = mask; dc_in = dc;
    for (int i = 0; i < 33; i++) nbr_in[i*8 +: 8] = nbr[i];
    r = 0; gapped = 0;
    while (r < BLK) begin
      @(negedge clk);
      start = 1'b0;
      if (stall && r == 5 && !gapped) begin
        src_valid = 1'b0; gapped = 1;
      end else begin
        src_valid = 1'b1;
        for (int c = 0; c < BLK; c++) src_row[c*8 +: 8] = src[r][c];
        if (r == 3 && p == 1) start = 1'b1; // R10: start during load
      end
      acc_row = src_valid && src_ready;
      if (acc_row) r++;
    end
    @(negedge clk);
    src_valid = 1'b0; start = 1'b0;
    k = 0; first = 1;
    while (k < BLK) begin
      @(negedge clk);
      start = 1'b0;
      pred_ready = stall ? cyc[0] : 1'b1;
      if (pred_valid) begin
        if (first) begin
          // R2 R3 R4 R5 R6: winner and cost from independent SAD sums
          chk(best_mode == 2'(em), "R6 mode", 128'(best_mode), 128'(em));
          chk(best_cost == 32'(ec), "R5 cost", 128'(best_cost), 128'(ec));
          if (poke) start = 1'b1;
          first = 0;
        end
        take = pred_ready;
        if (take) begin
          chk(pred_row == pack_row(em, k), "R7 row", pred_row, pack_row(em, k));
          k++;
        end
      end
    end
    @(negedge clk);
    start = 1'b0; pred_ready = 1'b0;
    chk(done == 1'b1, "R9 done high", 128'(done), 128'd1);
    @(negedge clk);
    chk(done == 1'b0, "R9 done single", 128'(done), 128'd0);
    chk(src_ready == 1'b0, "R10 no rearm", 128'(src_ready), 128'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(src_ready == 1'b0, "R1 reset src_ready", 128'(src_ready), 0);
    chk(pred_valid == 1'b0, "R1 reset pred_valid", 128'(pred_valid), 0);
    chk(done == 1'b0, "R1 reset done", 128'(done), 0);
    chk(best_mode == 2'd0 && best_cost == 32'd0, "R1 reset result", 128'(best_cost), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(src_ready == 1'b0, "R1 idle without start", 128'(src_ready), 0);
    for (int p = 0; p < 6; p++)
      for (int m = 0; m < 8; m++)
        run_block(p, 3'(m));
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule